// File: doc/BRIEF.md
# DMA Channel Request and Transfer Sequencer

This block is the per-channel control core of a DMA engine. It keeps the channel's control fields (enable, software start, slice mode, chain mode and slice size) and a remaining quad-word count. It merges software start writes and an active-low hardware request line into one pending request. It raises a bus request for arbitration and, once granted, counts quad-word beats. It then decides whether to release the bus after one slice or after the whole block.

Software writes the control word and the count through two write strobes with data. The bus side gives a request output, a grant input and a per-beat completion strobe. In normal mode the start bit clears as soon as the channel is granted. In chain mode the start bit stays set until the whole block has moved. Address generation and the data path live elsewhere.

Top module: `dma_chan_seq`

## Requirements
- R1: While the enable bit (control bit 0) is 0, bus_req_o is never asserted.
- R2: A control write with bit 1 set makes the start bit (start_o) 1 after the write edge. A control write with bit 1 clear leaves start_o unchanged.
- R3: With chain mode off (control bit 3 = 0), start_o goes to 0 in the cycle after the grant is accepted.
- R4: With chain mode on (control bit 3 = 1), start_o stays 1 through the grant and clears with the final beat of the block.
- R5: With slice mode off (control bit 2 = 0), one request moves the whole remaining count, and bus_req_o stays high until the count reaches zero.
- R6: With slice mode on, each request moves one slice. The slice size is given by control bits 6:4: codes 0 to 4 select 1 to 5 quad-words, and codes 5 to 7 select 5. The request drops after the slice or after the remaining count, whichever ends first.
- R7: After a slice ends, the channel does not request again until a new hardware request falling edge arrives or a start write occurs.
- R8: A count write loads remain_o. Each beat_done_i while granted decrements it. block_done_o pulses for one cycle in the cycle after the final beat.
- R9: hw_req_ni is active-low and passes through a two-flop synchroniser. Its falling edge raises bus_req_o four clock edges later on an idle enabled channel. A level held low does not re-request.
- R10: The grant is taken only while bus_req_o is high, and beat_done_i has no effect before the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 7 | Control word: bit0 enable, bit1 start, bit2 slice mode, bit3 chain mode, bits6:4 slice size |
| cnt_we_i | input | 1 | Remaining-count write strobe |
| cnt_wdata_i | input | 16 | Remaining-count value |
| hw_req_ni | input | 1 | Asynchronous active-low hardware request |
| bus_gnt_i | input | 1 | Bus grant |
| beat_done_i | input | 1 | One quad-word beat completed |
| bus_req_o | output | 1 | Bus request to the arbiter |
| start_o | output | 1 | Current start bit |
| remain_o | output | 16 | Remaining quad-word count |
| block_done_o | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
On every cycle the assertions check several properties. No request appears while the channel is disabled. A start write always sets the start bit. A normal-mode grant clears the start bit. A granted channel holds its request until a beat can end the run. A done pulse always leaves a zero count. The bench scenarios are needed for the rest. They show slice lengths for each size code, including the codes that saturate to five beats. They also cover the count running out in mid-slice, the chain-mode start bit lasting through a block, synchroniser latency, and the absence of re-requests after a slice.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int CTRL_W    = 7;
  localparam int EN_BIT    = 0;
  localparam int START_BIT = 1;
  localparam int SLICE_BIT = 2;
  localparam int CHAIN_BIT = 3;
  localparam int SZ_LSB    = 4;
  localparam int SZ_W      = 3;
  localparam int MAX_SLICE = 5;
  localparam int SLC_W     = $clog2(MAX_SLICE + 1);

  typedef struct packed {
    logic [SZ_W-1:0] sz;
    logic            chain;
    logic            slice;
    logic            en;
  } cfg_t;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic edge_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q[0] <= 1'b0;
    else         sh_q[0] <= ~req_ni;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q[i] <= 1'b0;
      else         sh_q[i] <= sh_q[i-1];
    end
  end

  // rising edge of the synchronised (active-high) request
  assign edge_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CTRL_W-1:0] cfg_wdata_i,
  input  logic              hw_edge_i,
  input  logic              grant_evt_i,
  input  logic              block_end_i,
  output cfg_t              cfg_o,
  output logic              start_o,
  output logic              req_pend_o
);
  cfg_t cfg_q;
  logic start_q, pend_q;
  logic start_wr;

  assign start_wr = cfg_we_i & cfg_wdata_i[START_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (cfg_we_i) begin
      cfg_q.en    <= cfg_wdata_i[EN_BIT];
      cfg_q.slice <= cfg_wdata_i[SLICE_BIT];
      cfg_q.chain <= cfg_wdata_i[CHAIN_BIT];
      cfg_q.sz    <= cfg_wdata_i[SZ_LSB +: SZ_W];
    end
  end

  // start bit: set on write of 1, auto-clear depends on chain mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  start_q <= 1'b0;
    else if (start_wr)                            start_q <= 1'b1;
    else if (cfg_q.chain ? block_end_i : grant_evt_i) start_q <= 1'b0;
  end

  // fresh-request latch: one launch per start write or hw edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pend_q <= 1'b0;
    else if (start_wr || hw_edge_i) pend_q <= 1'b1;
    else if (grant_evt_i)           pend_q <= 1'b0;
  end

  assign cfg_o      = cfg_q;
  assign start_o    = start_q;
  assign req_pend_o = pend_q;
endmodule

// File: rtl/dma_beat_ctr.sv
module dma_beat_ctr
  import dma_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             beat_i,
  input  logic             grant_evt_i,
  input  logic [SZ_W-1:0]  slice_sz_i,
  output logic [CNT_W-1:0] remain_o,
  output logic             remain_last_o,
  output logic             remain_zero_o,
  output logic             slice_last_o
);
  localparam logic [SLC_W-1:0] SLC_MAX = SLC_W'(MAX_SLICE);

  logic [CNT_W-1:0] rem_q;
  logic [SLC_W-1:0] slc_q, slc_load;

  always_comb begin
    if (SLC_W'(slice_sz_i) >= SLC_MAX - 1'b1) slc_load = SLC_MAX;
    else                                     slc_load = SLC_W'(slice_sz_i) + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rem_q <= '0;
    else if (cnt_we_i)               rem_q <= cnt_wdata_i;
    else if (beat_i && rem_q != '0)  rem_q <= rem_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     slc_q <= '0;
    else if (grant_evt_i)            slc_q <= slc_load;
    else if (beat_i && slc_q != '0)  slc_q <= slc_q - 1'b1;
  end

  assign remain_o      = rem_q;
  assign remain_zero_o = (rem_q == '0);
  assign remain_last_o = (rem_q <= CNT_W'(1));
  assign slice_last_o  = (slc_q == SLC_W'(1));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CTRL_W-1:0] cfg_wdata_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              hw_req_ni,
  input  logic              bus_gnt_i,
  input  logic              beat_done_i,
  output logic              bus_req_o,
  output logic              start_o,
  output logic [CNT_W-1:0]  remain_o,
  output logic              block_done_o
);
  cfg_t cfg;
  logic hw_edge, req_pend;
  logic busy_q, granted_q, done_q;
  logic grant_evt, beat, block_end, slice_end, run_end, launch;
  logic rem_last, rem_zero, slc_last;

  dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_ni(hw_req_ni),
    .edge_o(hw_edge)
  );

  dma_chan_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i),
    .hw_edge_i  (hw_edge),
    .grant_evt_i(grant_evt),
    .block_end_i(block_end),
    .cfg_o      (cfg),
    .start_o    (start_o),
    .req_pend_o (req_pend)
  );

  dma_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cnt_we_i     (cnt_we_i),
    .cnt_wdata_i  (cnt_wdata_i),
    .beat_i       (beat),
    .grant_evt_i  (grant_evt),
    .slice_sz_i   (cfg.sz),
    .remain_o     (remain_o),
    .remain_last_o(rem_last),
    .remain_zero_o(rem_zero),
    .slice_last_o (slc_last)
  );

  assign bus_req_o = cfg.en & busy_q;
  assign grant_evt = bus_req_o & bus_gnt_i & ~granted_q;
  assign beat      = granted_q & beat_done_i;
  assign block_end = beat & rem_last;
  assign slice_end = beat & cfg.slice & slc_last;
  assign run_end   = block_end | slice_end;
  assign launch    = cfg.en & req_pend & ~busy_q & ~rem_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      granted_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= block_end;
      if (launch)       busy_q <= 1'b1;
      else if (run_end) busy_q <= 1'b0;
      if (run_end)        granted_q <= 1'b0;
      else if (grant_evt) granted_q <= 1'b1;
    end
  end

  assign block_done_o = done_q;
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             chain_i,
  input logic             granted_i,
  input logic             cfg_we_i,
  input logic             cfg_start_i,
  input logic             cnt_we_i,
  input logic             bus_gnt_i,
  input logic             beat_done_i,
  input logic             bus_req_i,
  input logic             start_i,
  input logic [CNT_W-1:0] remain_i,
  input logic             block_done_i
);
  a_r1_no_req_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !bus_req_i);

  a_r2_start_write_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_start_i) |=> start_i);

  a_r3_start_clears_on_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_gnt_i && !granted_i && !chain_i && !(cfg_we_i && cfg_start_i))
    |=> !start_i);

  a_r5_hold_while_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (granted_i && en_i && !beat_done_i && !cfg_we_i) |=> bus_req_i);

  a_r8_done_leaves_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_done_i && !$past(cnt_we_i)) |-> (remain_i == '0));
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (cfg.en),
  .chain_i     (cfg.chain),
  .granted_i   (granted_q),
  .cfg_we_i    (cfg_we_i),
  .cfg_start_i (cfg_wdata_i[1]),
  .cnt_we_i    (cnt_we_i),
  .bus_gnt_i   (bus_gnt_i),
  .beat_done_i (beat_done_i),
  .bus_req_i   (bus_req_o),
  .start_i     (start_o),
  .remain_i    (remain_o),
  .block_done_i(block_done_o)
);

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_wdata = '0;
  logic        cnt_we = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic        hw_req_n = 1'b1;
  logic        gnt = 1'b0;
  logic        beat = 1'b0;
  logic        bus_req, start, done;
  logic [15:0] remain;

  int n_chk = 0, n_bad = 0, cyc = 0;

  // reference model state
  bit m_en, m_start, m_slc, m_chn, m_rp, m_busy, m_gnt, m_done;
  int m_sz, m_rem, m_sl;
  bit m_s1, m_s2, m_s3;

  always #5 clk = ~clk;

  dma_chan_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wdata), .hw_req_ni(hw_req_n),
    .bus_gnt_i(gnt), .beat_done_i(beat), .bus_req_o(bus_req), .start_o(start),
    .remain_o(remain), .block_done_o(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    bit req, gev, bt, bend, send, launch, hedge, wr_start;
    int slen;
    cyc++;
    if (!rst_ni) begin
      m_en = 0; m_start = 0; m_slc = 0; m_chn = 0; m_rp = 0; m_busy = 0;
      m_gnt = 0; m_done = 0; m_sz = 0; m_rem = 0; m_sl = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      req    = m_en && m_busy;
      gev    = req && gnt && !m_gnt;                     // R10
      bt     = m_gnt && beat;
      bend   = bt && (m_rem <= 1);                       // R5 / R8
      send   = bt && m_slc && (m_sl == 1);               // R6
      launch = m_en && m_rp && !m_busy && (m_rem != 0);
      hedge  = m_s2 && !m_s3;                            // R9
      wr_start = cfg_we && cfg_wdata[1];
      slen   = (m_sz >= 4) ? 5 : m_sz + 1;
      m_done = bend;
      if (wr_start) m_start = 1;                         // R2
      else if (m_chn ? bend : gev) m_start = 0;          // R3 / R4
      if (wr_start || hedge) m_rp = 1;                   // R7
      else if (gev) m_rp = 0;
      if (launch) m_busy = 1;
      else if (bend || send) m_busy = 0;
      if (bend || send) m_gnt = 0;
      else if (gev) m_gnt = 1;
      if (gev) m_sl = slen;
      else if (bt && m_sl != 0) m_sl--;
      if (cnt_we) m_rem = cnt_wdata;
      else if (bt && m_rem != 0) m_rem--;
      if (cfg_we) begin
        m_en = cfg_wdata[0]; m_slc = cfg_wdata[2]; m_chn = cfg_wdata[3];
        m_sz = cfg_wdata[6:4];
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = !hw_req_n;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      chk("R1 bus_req_o", bus_req, m_en && m_busy);
      chk("R2 start_o", start, m_start);
      chk("R8 remain_o", remain, m_rem);
      chk("R8 block_done_o", done, m_done);
    end
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wcfg(input bit en, input bit st, input bit slc, input bit chn, input int sz);
    cfg_wdata = {sz[2:0], chn, slc, st, en};
    cfg_we = 1; tick(); cfg_we = 0;
  endtask

  task automatic wcnt(input int v);
    cnt_wdata = v[15:0]; cnt_we = 1; tick(); cnt_we = 0;
  endtask

  task automatic hw_pulse();
    hw_req_n = 0; tick(3); hw_req_n = 1;
  endtask

  task automatic wait_req();
    for (int i = 0; i < 30 && !bus_req; i++) tick();
  endtask

  task automatic serve(output int nb);
    wait_req();
    gnt = 1; tick(); gnt = 0;
    beat = 1; nb = 0;
    do begin tick(); nb++; end while (bus_req && nb < 40);
    beat = 0;
  endtask

  initial begin
    int nb;
    tick(3);
    rst_ni = 1;
    tick();
    // reset state
    chk("R1 reset bus_req_o", bus_req, 0);
    chk("R2 reset start_o", start, 0);
    chk("R8 reset remain_o", remain, 0);

    // R5 block mode, software start
    wcnt(4);
    wcfg(1, 1, 0, 0, 0);
    serve(nb);
    chk("R5 block beats", nb, 4);
    chk("R8 done pulse", done, 1);
    chk("R3 start cleared", start, 0);
    tick();
    chk("R8 done one cycle", done, 0);

    // R1 disabled channel never requests; R2 zero write ignored
    wcnt(3);
    wcfg(0, 1, 0, 0, 0);
    tick(6);
    chk("R1 no request when disabled", bus_req, 0);
    wcfg(0, 0, 0, 0, 0);
    chk("R2 zero write keeps start", start, 1);
    wcfg(1, 0, 0, 0, 0);
    serve(nb);
    chk("R5 block after enable", nb, 3);

    // R6 / R7 slice mode with hw request, size code 1 = 2 beats
    wcnt(5);
    wcfg(1, 0, 1, 0, 1);
    hw_pulse();
    serve(nb);
    chk("R6 slice of two", nb, 2);
    chk("R6 remain after slice", remain, 3);
    tick(8);
    chk("R7 no re-request", bus_req, 0);
    hw_pulse();
    serve(nb);
    chk("R6 second slice", nb, 2);
    hw_pulse();
    serve(nb);
    chk("R6 count ends slice", nb, 1);
    chk("R8 done at end", done, 1);

    // R6 codes 7 and 4 saturate to five
    wcnt(9);
    wcfg(1, 1, 1, 0, 7);
    serve(nb);
    chk("R6 code 7 slice", nb, 5);
    wcfg(1, 1, 1, 0, 7);
    serve(nb);
    chk("R6 short tail", nb, 4);
    wcnt(6);
    wcfg(1, 1, 1, 0, 4);
    serve(nb);
    chk("R6 code 4 slice", nb, 5);
    wcfg(1, 1, 1, 0, 0);
    serve(nb);
    chk("R6 code 0 slice", nb, 1);

    // R4 chain mode: start stays until block finishes
    wcnt(3);
    wcfg(1, 1, 0, 1, 0);
    wait_req();
    gnt = 1; tick(); gnt = 0;
    chk("R4 start held after grant", start, 1);
    tick(2);
    beat = 1; tick(2);
    chk("R4 start held mid block", start, 1);
    tick(); beat = 0;
    chk("R4 start cleared at end", start, 0);
    chk("R5 request released", bus_req, 0);

    // R9 synchroniser latency, R10 beats before grant ignored
    wcnt(2);
    wcfg(1, 0, 0, 0, 0);
    hw_req_n = 0;
    tick(3);
    chk("R9 not yet requesting", bus_req, 0);
    tick();
    chk("R9 request after four edges", bus_req, 1);
    beat = 1; tick(3); beat = 0;
    chk("R10 beats before grant ignored", remain, 2);
    serve(nb);
    chk("R9 hw block", nb, 2);
    wcnt(2);
    tick(10);
    chk("R9 held level no re-request", bus_req, 0);
    hw_req_n = 1;
    tick(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule